// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block sits between a host that issues configuration-space requests and a 32-bit memory-mapped master port. The port reaches a bridge's address-window control register and its configuration window. Each host request names a bus, device, function, register offset, byte count and direction. The block first points the bridge's window at the correct cycle type. It then performs one dword access inside the configuration window.

On bus 0 the device is selected by a one-hot IDSEL bit. Bits that fall above the window move into the window control register. Any other bus gets an encoded Type 1 address. Reads come back shifted down to the addressed byte lane and trimmed to the requested size. One- and two-byte writes become a read, a lane merge and a write-back of the same dword.

Illegal requests are answered with an error at once and make no bus traffic. A bus error on the master port ends the request with all-ones data and an error flag. Only one request is in flight at a time.

Top module: `cfg_access_xlate`

## Requirements
- R1: A bus-0 request with device d < 16 writes the window register with (1 << (d+16)) masked to bits 31:26, ORed with selector 2'b10 in bits 1:0. It then accesses CFG_BASE | ((1 << (d+16)) & 32'h03FF_0000) | func<<8 | {offset[7:2],2'b00}.
- R2: A request on a non-zero bus writes the window register with selector 2'b11 (no other bits). It then accesses CFG_BASE | bus<<16 | device<<11 | func<<8 | {offset[7:2],2'b00}.
- R3: A bus-0 request whose device is 16 or above completes with resp_err=1 and resp_rdata=32'hFFFF_FFFF, and makes no master access.
- R4: With cardbus_mode high, any request with device above 1 is rejected as in R3; device 0 or 1 proceeds normally.
- R5: A size other than 1, 2 or 4 is rejected as in R3.
- R6: A read returns the fetched dword shifted right by 8*offset[1:0], then masked to the low 8, 16 or 32 bits for size 1, 2 or 4.
- R7: A 1- or 2-byte write reads the dword and replaces only the addressed lanes with the low size bytes of req_wdata shifted left by 8*offset[1:0]. It writes the merged dword to the same address.
- R8: A 4-byte write performs the window write and then a single write of req_wdata, with no read.
- R9: If the master port reports m_err on an access, the request completes with resp_err=1 and resp_rdata all-ones, and no further access follows. In particular, the write-back of a sub-word write is not issued.
- R10: req_ready is high only when idle. It drops in the cycle after acceptance and stays low until the completion cycle has passed.
- R11: Completion is a one-cycle resp_done with resp_err. A successful write returns resp_rdata=0.
- R12: Every accepted legal request begins with the window-register write at WIN_ADDR. The master holds m_valid, m_addr and m_write steady until m_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cardbus_mode | input | 1 | Restricts devices to 0 and 1 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_off | input | 8 | Register byte offset |
| req_size | input | 3 | Byte count (1, 2 or 4 legal) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, right-aligned |
| resp_done | output | 1 | One-cycle completion strobe |
| resp_err | output | 1 | Completion carries an error |
| resp_rdata | output | 32 | Aligned read data |
| m_valid | output | 1 | Master access request |
| m_write | output | 1 | Master access is a write |
| m_addr | output | 32 | Master address |
| m_wdata | output | 32 | Master write data |
| m_ready | input | 1 | Access accepted and answered this cycle |
| m_rdata | input | 32 | Master read data |
| m_err | input | 1 | Master access failed |

## Verification
The delicate overlap is a bus error landing on the read half of a sub-word write. In that one cycle the error path and the lane-merge path both want to set the next step. The bench injects m_err only on configuration-window reads during a one-byte write. It then judges that exactly two master accesses occurred (window write, read), that no write was issued, and that the completion carried all-ones with the error flag. The same injection on a plain read confirms that the error data replaces the aligned data rather than mixing with it.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WIN,
    ST_RD,
    ST_WR,
    ST_DONE
  } seq_state_e;

  function automatic logic size_legal(input logic [2:0] size);
    return (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
  endfunction

  function automatic logic [31:0] lane_mask(input logic [2:0] size);
    case (size)
      3'd1:    return 32'h0000_00FF;
      3'd2:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] read_align(input logic [31:0] word,
                                             input logic [1:0]  lane,
                                             input logic [2:0]  size);
    logic [4:0] sh;
    sh = {lane, 3'b000};
    return (word >> sh) & lane_mask(size);
  endfunction

  function automatic logic [31:0] write_merge(input logic [31:0] old_word,
                                              input logic [31:0] new_data,
                                              input logic [1:0]  lane,
                                              input logic [2:0]  size);
    logic [4:0]  sh;
    logic [31:0] m;
    sh = {lane, 3'b000};
    m  = lane_mask(size) << sh;
    return (old_word & ~m) | ((new_data & lane_mask(size)) << sh);
  endfunction

endpackage

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen #(
  parameter int          BUS_W        = 8,
  parameter int          DEV_W        = 5,
  parameter int          FUNC_W       = 3,
  parameter int          OFF_W        = 8,
  parameter int          T0_DEV_LIMIT = 16,
  parameter logic [31:0] CFG_BASE     = 32'h0C00_0000,
  parameter logic [31:0] WIN_HI_MASK  = 32'hFC00_0000,
  parameter logic [1:0]  SEL_T0       = 2'b10,
  parameter logic [1:0]  SEL_T1       = 2'b11
) (
  input  logic [BUS_W-1:0]  bus,
  input  logic [DEV_W-1:0]  dev,
  input  logic [FUNC_W-1:0] func,
  input  logic [OFF_W-1:2]  off_dw,
  input  logic [2:0]        size,
  input  logic              cardbus,
  output logic [31:0]       win_val,
  output logic [31:0]       cfg_addr,
  output logic              legal
);
  import cfg_xlate_pkg::*;

  localparam int IDSEL_BASE = 16;

  logic        is_t0;
  logic [31:0] idsel;
  logic [31:0] low_bits;
  logic        dev_ok;

  assign is_t0    = (bus == '0);
  assign idsel    = 32'd1 << (32'(dev) + IDSEL_BASE);
  assign low_bits = (32'(func) << 8) | (32'(off_dw) << 2);

  always_comb begin
    dev_ok = 1'b1;
    if (cardbus && (32'(dev) > 1)) dev_ok = 1'b0;
    if (is_t0 && (32'(dev) >= T0_DEV_LIMIT)) dev_ok = 1'b0;
  end

  assign legal = dev_ok && size_legal(size);

  always_comb begin
    if (is_t0) begin
      win_val  = (idsel & WIN_HI_MASK) | 32'(SEL_T0);
      cfg_addr = CFG_BASE | (idsel & ~WIN_HI_MASK) | low_bits;
    end else begin
      win_val  = 32'(SEL_T1);
      cfg_addr = CFG_BASE | (32'(bus) << 16) | (32'(dev) << 11) | low_bits;
    end
  end

endmodule

// File: rtl/cfg_lane_unit.sv
module cfg_lane_unit (
  input  logic [31:0] rd_word,
  input  logic [31:0] wr_data,
  input  logic [1:0]  lane,
  input  logic [2:0]  size,
  output logic [31:0] aligned,
  output logic [31:0] merged
);
  import cfg_xlate_pkg::*;

  assign aligned = read_align(rd_word, lane, size);
  assign merged  = write_merge(rd_word, wr_data, lane, size);

endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_xlate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       legal,
  input  logic       is_write,
  input  logic       full_word,
  input  logic       m_fire,
  input  logic       m_err,
  output seq_state_e state
);

  seq_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (accept) nxt = legal ? ST_WIN : ST_DONE;
      ST_WIN:  if (m_fire) begin
        if (m_err)                      nxt = ST_DONE;
        else if (is_write && full_word) nxt = ST_WR;
        else                            nxt = ST_RD;
      end
      ST_RD:   if (m_fire) nxt = (m_err || !is_write) ? ST_DONE : ST_WR;
      ST_WR:   if (m_fire) nxt = ST_DONE;
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

endmodule

// File: rtl/cfg_access_xlate.sv
module cfg_access_xlate
  import cfg_xlate_pkg::*;
#(
  parameter logic [31:0] CFG_BASE = 32'h0C00_0000,
  parameter logic [31:0] WIN_ADDR = 32'h0000_0104
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cardbus_mode,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [7:0]  req_bus,
  input  logic [4:0]  req_dev,
  input  logic [2:0]  req_func,
  input  logic [7:0]  req_off,
  input  logic [2:0]  req_size,
  input  logic        req_write,
  input  logic [31:0] req_wdata,
  output logic        resp_done,
  output logic        resp_err,
  output logic [31:0] resp_rdata,
  output logic        m_valid,
  output logic        m_write,
  output logic [31:0] m_addr,
  output logic [31:0] m_wdata,
  input  logic        m_ready,
  input  logic [31:0] m_rdata,
  input  logic        m_err
);

  localparam logic [31:0] ALL_ONES = 32'hFFFF_FFFF;

  seq_state_e  state;
  logic        accept;
  logic        req_legal;
  logic        m_fire;
  logic [31:0] gen_win;
  logic [31:0] gen_addr;
  logic [31:0] aligned;
  logic [31:0] merged;

  logic [31:0] lat_win;
  logic [31:0] lat_addr;
  logic [1:0]  lat_lane;
  logic [2:0]  lat_size;
  logic        lat_write;
  logic [31:0] lat_wdata;
  logic [31:0] merge_q;
  logic        err_q;
  logic [31:0] data_q;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign m_fire    = m_valid && m_ready;

  cfg_addr_gen #(
    .CFG_BASE (CFG_BASE)
  ) u_addr (
    .bus      (req_bus),
    .dev      (req_dev),
    .func     (req_func),
    .off_dw   (req_off[7:2]),
    .size     (req_size),
    .cardbus  (cardbus_mode),
    .win_val  (gen_win),
    .cfg_addr (gen_addr),
    .legal    (req_legal)
  );

  cfg_lane_unit u_lane (
    .rd_word (m_rdata),
    .wr_data (lat_wdata),
    .lane    (lat_lane),
    .size    (lat_size),
    .aligned (aligned),
    .merged  (merged)
  );

  cfg_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .legal     (req_legal),
    .is_write  (lat_write),
    .full_word (lat_size == 3'd4),
    .m_fire    (m_fire),
    .m_err     (m_err),
    .state     (state)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_win   <= '0;
      lat_addr  <= '0;
      lat_lane  <= '0;
      lat_size  <= '0;
      lat_write <= 1'b0;
      lat_wdata <= '0;
    end else if (accept) begin
      lat_win   <= gen_win;
      lat_addr  <= gen_addr;
      lat_lane  <= req_off[1:0];
      lat_size  <= req_size;
      lat_write <= req_write;
      lat_wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      data_q  <= '0;
      merge_q <= '0;
    end else begin
      if (accept) begin
        err_q  <= !req_legal;
        data_q <= req_legal ? 32'd0 : ALL_ONES;
      end
      if (m_fire) begin
        if (m_err) begin
          err_q  <= 1'b1;
          data_q <= ALL_ONES;
        end else if (state == ST_RD) begin
          if (lat_write) merge_q <= merged;
          else           data_q  <= aligned;
        end
      end
    end
  end

  always_comb begin
    m_valid = (state == ST_WIN) || (state == ST_RD) || (state == ST_WR);
    m_write = (state == ST_WIN) || (state == ST_WR);
    m_addr  = (state == ST_WIN) ? WIN_ADDR : lat_addr;
    if (state == ST_WIN)        m_wdata = lat_win;
    else if (lat_size == 3'd4)  m_wdata = lat_wdata;
    else                        m_wdata = merge_q;
  end

  assign resp_done  = (state == ST_DONE);
  assign resp_err   = err_q;
  assign resp_rdata = data_q;

endmodule

// File: rtl/cfg_xlate_chk.sv
module cfg_xlate_chk
  import cfg_xlate_pkg::*;
#(
  parameter logic [31:0] WIN_ADDR = 32'h0000_0104
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [2:0]  req_size,
  input logic        req_legal,
  input logic        resp_done,
  input logic        resp_err,
  input logic [31:0] resp_rdata,
  input logic        m_valid,
  input logic        m_write,
  input logic [31:0] m_addr,
  input logic        m_ready,
  input logic        m_err
);

  assert_ready_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |=> !resp_done);

  assert_err_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_done && resp_err) |-> (resp_rdata == 32'hFFFF_FFFF));

  assert_stop_after_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && m_err) |=> !m_valid);

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write)));

  assert_bad_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !size_legal(req_size)) |=> !m_valid);

  assert_window_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_legal) |=> (m_valid && m_write && m_addr == WIN_ADDR));

endmodule

bind cfg_access_xlate cfg_xlate_chk #(.WIN_ADDR(WIN_ADDR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_size   (req_size),
  .req_legal  (req_legal),
  .resp_done  (resp_done),
  .resp_err   (resp_err),
  .resp_rdata (resp_rdata),
  .m_valid    (m_valid),
  .m_write    (m_write),
  .m_addr     (m_addr),
  .m_ready    (m_ready),
  .m_err      (m_err)
);

// File: tb/tb_cfg_access_xlate.sv
`timescale 1ns/1ps
module tb_cfg_access_xlate;

  localparam logic [31:0] BASE = 32'h0C00_0000;
  localparam logic [31:0] WADR = 32'h0000_0104;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cardbus_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_bus = '0;
  logic [4:0]  req_dev = '0;
  logic [2:0]  req_func = '0;
  logic [7:0]  req_off = '0;
  logic [2:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        resp_done, resp_err;
  logic [31:0] resp_rdata;
  logic        m_valid, m_write, m_ready, m_err;
  logic [31:0] m_addr, m_wdata, m_rdata;

  logic [31:0] cfg_word = 32'hAABB_CCDD;
  logic        err_inj = 1'b0;

  int total = 0;
  int bad = 0;

  logic [31:0] lg_addr [256];
  logic [31:0] lg_data [256];
  logic        lg_wr   [256];
  int          nlog = 0;

  logic [31:0] got_data;
  logic        got_err;
  int          base_idx;
  int          acc;

  always #5 clk = ~clk;

  cfg_access_xlate #(.CFG_BASE(BASE), .WIN_ADDR(WADR)) dut (
    .clk(clk), .rst_n(rst_n), .cardbus_mode(cardbus_mode),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func),
    .req_off(req_off), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata),
    .resp_done(resp_done), .resp_err(resp_err), .resp_rdata(resp_rdata),
    .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_ready(m_ready), .m_rdata(m_rdata), .m_err(m_err)
  );

  assign m_ready = m_valid;
  assign m_rdata = cfg_word;
  assign m_err   = err_inj && m_valid && !m_write && (m_addr != WADR);

  always @(posedge clk) begin
    if (m_valid && m_ready) begin
      lg_addr[nlog % 256] = m_addr;
      lg_data[nlog % 256] = m_wdata;
      lg_wr[nlog % 256]   = m_write;
      nlog = nlog + 1;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic [7:0] b, input logic [4:0] d, input logic [2:0] f,
                        input logic [7:0] o, input logic [2:0] s, input logic w,
                        input logic [31:0] wd);
    int ready_hi = 0;
    int waited = 0;
    @(negedge clk);
    base_idx  = nlog;
    req_bus = b; req_dev = d; req_func = f; req_off = o;
    req_size = s; req_write = w; req_wdata = wd; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_done && waited < 100) begin
      if (req_ready) ready_hi++;
      @(negedge clk);
      waited++;
    end
    got_data = resp_rdata;
    got_err  = resp_err;
    acc      = nlog - base_idx;
    chk(ready_hi == 0 && waited < 100, "R10 ready low while busy", 32'(ready_hi), 0);
    @(negedge clk);
    chk(!resp_done && req_ready, "R11 done lasts one cycle", {31'd0, resp_done}, 0);
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R10 reset ready", {31'd0, req_ready}, 1);
    chk(!resp_done && !m_valid, "R11 reset idle outputs", {30'd0, resp_done, m_valid}, 0);
  endtask

  task automatic t_type0;
    cfg_word = 32'hAABB_CCDD;
    do_req(8'd0, 5'd3, 3'd2, 8'h46, 3'd1, 1'b0, 0);
    chk(acc == 2, "R12 two accesses", 32'(acc), 2);
    chk(lg_wr[base_idx] && lg_addr[base_idx] == WADR, "R12 window first", lg_addr[base_idx], WADR);
    chk(lg_data[base_idx] == 32'h0000_0002, "R1 window value", lg_data[base_idx], 32'h2);
    chk(lg_addr[base_idx+1] == 32'h0C08_0244, "R1 type0 address", lg_addr[base_idx+1], 32'h0C08_0244);
    chk(got_data == 32'hBB && !got_err, "R6 byte lane 2", got_data, 32'hBB);
  endtask

  task automatic t_type0_hi;
    do_req(8'd0, 5'd12, 3'd0, 8'h10, 3'd4, 1'b0, 0);
    chk(lg_data[base_idx] == 32'h1000_0002, "R1 upper idsel in window", lg_data[base_idx], 32'h1000_0002);
    chk(lg_addr[base_idx+1] == 32'h0C00_0010, "R1 address without upper idsel", lg_addr[base_idx+1], 32'h0C00_0010);
    chk(got_data == 32'hAABB_CCDD, "R6 full word", got_data, 32'hAABB_CCDD);
  endtask

  task automatic t_type1;
    do_req(8'd5, 5'd7, 3'd1, 8'h0E, 3'd2, 1'b0, 0);
    chk(lg_data[base_idx] == 32'h0000_0003, "R2 window selector", lg_data[base_idx], 32'h3);
    chk(lg_addr[base_idx+1] == 32'h0C05_390C, "R2 type1 address", lg_addr[base_idx+1], 32'h0C05_390C);
    chk(got_data == 32'hAABB, "R6 half at lane 2", got_data, 32'hAABB);
    do_req(8'd5, 5'd7, 3'd1, 8'h0F, 3'd2, 1'b0, 0);
    chk(got_data == 32'hAA, "R6 half at lane 3 truncated", got_data, 32'hAA);
  endtask

  task automatic t_reject;
    do_req(8'd0, 5'd16, 3'd0, 8'h00, 3'd4, 1'b0, 0);
    chk(acc == 0, "R3 no access", 32'(acc), 0);
    chk(got_err && got_data == 32'hFFFF_FFFF, "R3 error ones", got_data, 32'hFFFF_FFFF);
    do_req(8'd2, 5'd20, 3'd0, 8'h00, 3'd4, 1'b0, 0);
    chk(acc == 2 && !got_err, "R2 high device legal on other bus", 32'(acc), 2);
    do_req(8'd0, 5'd1, 3'd0, 8'h00, 3'd3, 1'b0, 0);
    chk(acc == 0 && got_err, "R5 size 3 rejected", 32'(acc), 0);
    do_req(8'd0, 5'd1, 3'd0, 8'h00, 3'd0, 1'b1, 0);
    chk(acc == 0 && got_err && got_data == 32'hFFFF_FFFF, "R5 size 0 rejected", got_data, 32'hFFFF_FFFF);
  endtask

  task automatic t_cardbus;
    cardbus_mode = 1'b1;
    do_req(8'd1, 5'd2, 3'd0, 8'h00, 3'd4, 1'b0, 0);
    chk(acc == 0 && got_err, "R4 device 2 rejected", 32'(acc), 0);
    do_req(8'd0, 5'd1, 3'd0, 8'h00, 3'd4, 1'b0, 0);
    chk(acc == 2 && !got_err, "R4 device 1 allowed", 32'(acc), 2);
    chk(lg_addr[base_idx+1] == 32'h0C02_0000, "R4 device 1 address", lg_addr[base_idx+1], 32'h0C02_0000);
    cardbus_mode = 1'b0;
  endtask

  task automatic t_rmw;
    cfg_word = 32'h1122_3344;
    do_req(8'd0, 5'd0, 3'd0, 8'h41, 3'd1, 1'b1, 32'hFFFF_FF5A);
    chk(acc == 3, "R7 three accesses", 32'(acc), 3);
    chk(!lg_wr[base_idx+1] && lg_wr[base_idx+2], "R7 read then write", {30'd0, lg_wr[base_idx+1], lg_wr[base_idx+2]}, 1);
    chk(lg_data[base_idx+2] == 32'h1122_5A44, "R7 byte merge", lg_data[base_idx+2], 32'h1122_5A44);
    chk(lg_addr[base_idx+2] == lg_addr[base_idx+1], "R7 same address", lg_addr[base_idx+2], lg_addr[base_idx+1]);
    chk(got_data == 32'd0 && !got_err, "R11 write returns zero", got_data, 0);
    do_req(8'd0, 5'd0, 3'd0, 8'h42, 3'd2, 1'b1, 32'hFFFF_BEEF);
    chk(lg_data[base_idx+2] == 32'hBEEF_3344, "R7 half merge", lg_data[base_idx+2], 32'hBEEF_3344);
  endtask

  task automatic t_write4;
    do_req(8'd3, 5'd4, 3'd0, 8'h20, 3'd4, 1'b1, 32'hCAFE_F00D);
    chk(acc == 2, "R8 no read", 32'(acc), 2);
    chk(lg_wr[base_idx+1] && lg_data[base_idx+1] == 32'hCAFE_F00D, "R8 full data", lg_data[base_idx+1], 32'hCAFE_F00D);
  endtask

  task automatic t_buserr;
    err_inj = 1'b1;
    do_req(8'd0, 5'd2, 3'd0, 8'h01, 3'd1, 1'b0, 0);
    chk(got_err && got_data == 32'hFFFF_FFFF, "R9 read error ones", got_data, 32'hFFFF_FFFF);
    do_req(8'd0, 5'd2, 3'd0, 8'h01, 3'd1, 1'b1, 32'h77);
    chk(acc == 2, "R9 write phase suppressed", 32'(acc), 2);
    chk(got_err && got_data == 32'hFFFF_FFFF, "R9 write error ones", got_data, 32'hFFFF_FFFF);
    err_inj = 1'b0;
    do_req(8'd0, 5'd2, 3'd0, 8'h00, 3'd4, 1'b0, 0);
    chk(!got_err, "R9 error clears on next request", {31'd0, got_err}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_type0();
    t_type0_hi();
    t_type1();
    t_reject();
    t_cardbus();
    t_rmw();
    t_write4();
    t_buserr();
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule